// File: doc/BRIEF.md
# Multichannel Edge Time Tagger

The block watches four pulse lines that are already synchronous to its clock and marks every low-to-high transition with the value of a free-running cycle counter. The clock period is the time bin. In every cycle where at least one line rises, a single record is formed. The record carries the current timestamp and a channel mask with one bit per line, so edges that share a bin appear together as one coincidence record. The design targets clocks from 48 MHz up to 96 MHz and keeps one register stage of logic between the inputs and the record.

The counter can be restarted by a rising edge on either an external start pin or a host-driven start bit. When the counter wraps, a marker record with an empty mask is emitted so that the reader can extend the time base. Records go into an internal FIFO that is drained through a valid/ready port. When the FIFO is full, new records are discarded and a sticky overflow flag is raised until the host clears it.

Control is held in two small state machines. The marker machine has two states, MK_IDLE and MK_PEND. It moves from MK_IDLE to MK_PEND when the counter wraps. It returns to MK_IDLE in the first cycle without a rising edge, which is the cycle in which the marker is written. The overflow machine has two states, OVF_CLEAN and OVF_SET. It moves from OVF_CLEAN to OVF_SET on a dropped record. It returns to OVF_SET→OVF_CLEAN when the clear input is high in a cycle with no drop.

Top module: `edge_time_tagger`

## Requirements
- R1: Channel i is tagged in a cycle where `pulse_in[i]` is sampled high and was sampled low in the previous cycle. Just after reset every line counts as previously high, so a line held high through reset is not tagged.
- R2: A record is `TS_W+N_CH` bits wide (36 at defaults). The timestamp sits in bits `[TS_W+N_CH-1:N_CH]` and the mask in bits `[N_CH-1:0]`, with bit i set when channel i rose. All channels that rise in the same cycle share one record.
- R3: No record is written in a cycle without a rising edge, except the wrap marker of R7.
- R4: After a tag, a channel gives no second tag in the next cycle. A new tag needs at least one sampled-low cycle, so a line held high is tagged once.
- R5: The timestamp starts at 0 after reset and rises by one per cycle. The restart condition is a rising edge of `start_ext | start_host`. In that cycle the timestamp is 0, in the next it is 1, and a held start does not restart again.
- R6: An edge in the same cycle as a start edge carries timestamp 0.
- R7: A cycle whose timestamp is all ones and which has no start edge arms a wrap marker. The marker has mask `0000` and carries the timestamp of the cycle it is written in. It is written in the first following cycle with no rising edge.
- R8: `rec_valid` is high while the FIFO holds a record. Records leave in write order, one per cycle with `rec_valid && rec_ready`. `rec_data` stays stable while a record waits.
- R9: The FIFO is judged full from its fill level at the start of the cycle, even if a read happens in that same cycle. A record arriving when the FIFO is full is dropped, and `ovf_flag` reads 1 from the next cycle.
- R10: `ovf_flag` stays high until `ovf_clear` is sampled high in a cycle with no drop. The flag reads 0 from the next cycle. A drop in the clear cycle wins.
- R11: During and right after reset, `rec_valid` and `ovf_flag` are 0 and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one time bin |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_in | input | N_CH | Synchronized pulse lines |
| start_ext | input | 1 | External counter restart line |
| start_host | input | 1 | Host-driven counter restart bit |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| rec_ready | input | 1 | Reader accepts the head record |
| rec_valid | output | 1 | A record is available |
| rec_data | output | TS_W+N_CH | Head record: timestamp above, channel mask below |
| ovf_flag | output | 1 | Sticky record-drop indicator |

## Verification
Several internal faults show up one cycle later as a wrong timestamp field in the next record. These include a wrong counter value, a missed start edge, and a stale previous-sample register; a stale previous-sample register can also cause a missing or duplicated record. A wrong fill count in the FIFO shows up either as early or late drops, which the flag reveals one cycle later, or as a reordered or repeated record at the read port. A marker machine stuck in MK_PEND writes empty-mask records in every quiet cycle, so the fault is visible at the port within a cycle or two.

// File: rtl/ett_pkg.sv
package ett_pkg;
    typedef enum logic {
        MK_IDLE,
        MK_PEND
    } mark_state_t;

    typedef enum logic {
        OVF_CLEAN,
        OVF_SET
    } ovf_state_t;
endpackage

// File: rtl/ett_rise_detect.sv
module ett_rise_detect #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] pulse_in,
    output logic [N_CH-1:0] rise
);
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic prev_q;

        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b1;
            else        prev_q <= pulse_in[i];
        end

        assign rise[i] = pulse_in[i] & ~prev_q;

        // R4: one cycle of dead time after each tag
        a_r4_dead_time: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> !rise[i]);
    end
endmodule

// File: rtl/ett_timebase.sv
module ett_timebase #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_ext,
    input  logic            start_host,
    output logic [TS_W-1:0] ts_now,
    output logic            start_edge,
    output logic            wrap_set
);
    logic            start_q;
    logic [TS_W-1:0] cnt_q;
    logic            start_any;

    assign start_any  = start_ext | start_host;
    assign start_edge = start_any & ~start_q;
    assign ts_now     = start_edge ? '0 : cnt_q;
    assign wrap_set   = !start_edge && (cnt_q == {TS_W{1'b1}});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            start_q <= start_any;
            cnt_q   <= start_edge ? TS_W'(1) : cnt_q + TS_W'(1);
        end
    end

    // R5: timestamp reads one in the cycle after a restart
    a_r5_restart_one: assert property (@(posedge clk) disable iff (!rst_n)
        start_edge |=> ts_now == TS_W'(1));
    // R5: otherwise the timestamp steps by one
    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (start_edge || ts_now == TS_W'($past(ts_now) + TS_W'(1))));
endmodule

// File: rtl/ett_record_fsm.sv
module ett_record_fsm
    import ett_pkg::*;
#(
    parameter int TS_W = 32,
    parameter int N_CH = 4,
    localparam int REC_W = TS_W + N_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CH-1:0]  rise,
    input  logic [TS_W-1:0]  ts_now,
    input  logic             wrap_set,
    output logic             push,
    output logic [REC_W-1:0] push_data
);
    mark_state_t state_q, state_d;
    logic        any_rise;

    assign any_rise = |rise;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MK_IDLE: if (wrap_set)  state_d = MK_PEND;
            MK_PEND: if (!any_rise) state_d = MK_IDLE;
        endcase
    end

    always_comb begin
        push      = 1'b0;
        push_data = {ts_now, rise};
        unique case (state_q)
            MK_IDLE: push = any_rise;
            MK_PEND: push = 1'b1;
        endcase
    end

    // R7: a wrap always leaves a marker pending
    a_r7_wrap_arms: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_set |=> state_q == MK_PEND);
    // R3: an empty-mask write only while a marker is owed
    a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !any_rise) |=> state_q == MK_IDLE);
endmodule

// File: rtl/ett_fifo.sv
module ett_fifo #(
    parameter int W     = 36,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         dropped
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] level;
    logic          full, accept, pop;

    assign full      = (level == CW'(DEPTH));
    assign accept    = push && !full;
    assign dropped   = push && full;
    assign out_valid = (level != '0);
    assign pop       = out_valid && out_ready;
    assign out_data  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (accept) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (pop)    rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            level <= level + CW'(accept) - CW'(pop);
        end
    end

    // R8: a waiting record holds still
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R9: a full FIFO without a read stays full
    a_r9_stay_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);
    // R9: fill level never passes the depth
    a_r9_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));
endmodule

// File: rtl/edge_time_tagger.sv
module edge_time_tagger
    import ett_pkg::*;
#(
    parameter int TS_W  = 32,
    parameter int N_CH  = 4,
    parameter int DEPTH = 16,
    localparam int REC_W = TS_W + N_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CH-1:0]  pulse_in,
    input  logic             start_ext,
    input  logic             start_host,
    input  logic             ovf_clear,
    input  logic             rec_ready,
    output logic             rec_valid,
    output logic [REC_W-1:0] rec_data,
    output logic             ovf_flag
);
    logic [N_CH-1:0]  rise;
    logic [TS_W-1:0]  ts_now;
    logic             start_edge, wrap_set;
    logic             push, dropped;
    logic [REC_W-1:0] push_data;
    ovf_state_t       ovf_q, ovf_d;

    ett_rise_detect #(.N_CH(N_CH)) u_rise (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .rise(rise)
    );

    ett_timebase #(.TS_W(TS_W)) u_time (
        .clk(clk), .rst_n(rst_n), .start_ext(start_ext), .start_host(start_host),
        .ts_now(ts_now), .start_edge(start_edge), .wrap_set(wrap_set)
    );

    ett_record_fsm #(.TS_W(TS_W), .N_CH(N_CH)) u_rec (
        .clk(clk), .rst_n(rst_n), .rise(rise), .ts_now(ts_now),
        .wrap_set(wrap_set), .push(push), .push_data(push_data)
    );

    ett_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .out_ready(rec_ready), .out_valid(rec_valid), .out_data(rec_data),
        .dropped(dropped)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= OVF_CLEAN;
        else        ovf_q <= ovf_d;
    end

    always_comb begin
        ovf_d = ovf_q;
        unique case (ovf_q)
            OVF_CLEAN: if (dropped)                ovf_d = OVF_SET;
            OVF_SET:   if (ovf_clear && !dropped)  ovf_d = OVF_CLEAN;
        endcase
    end

    always_comb begin
        ovf_flag = 1'b0;
        unique case (ovf_q)
            OVF_CLEAN: ovf_flag = 1'b0;
            OVF_SET:   ovf_flag = 1'b1;
        endcase
    end

    // R9: a drop always shows on the flag next cycle
    a_r9_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |=> ovf_flag);
    // R10: the flag is sticky without a clear
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clear) |=> ovf_flag);
    // R6: an edge with a start edge is stamped zero
    a_r6_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (start_edge && push) |-> push_data[REC_W-1:N_CH] == '0);
endmodule

// File: tb/tb_edge_time_tagger.sv
module tb_edge_time_tagger;
    localparam int TS_W  = 10;
    localparam int N_CH  = 4;
    localparam int DEPTH = 4;
    localparam int REC_W = TS_W + N_CH;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_CH-1:0]  pulse_in = '0;
    logic             start_ext = 1'b0, start_host = 1'b0;
    logic             ovf_clear = 1'b0, rec_ready = 1'b0;
    logic             rec_valid, ovf_flag;
    logic [REC_W-1:0] rec_data;

    int errors = 0, checks = 0, markers = 0;
    bit done = 0;

    // model state, derived from the requirements
    logic [REC_W-1:0] mq[$];
    logic [N_CH-1:0]  m_prev;
    logic             m_sprev, m_pend, m_ovf;
    logic [TS_W-1:0]  m_cnt;

    edge_time_tagger #(.TS_W(TS_W), .N_CH(N_CH), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .start_ext(start_ext),
        .start_host(start_host), .ovf_clear(ovf_clear), .rec_ready(rec_ready),
        .rec_valid(rec_valid), .rec_data(rec_data), .ovf_flag(ovf_flag)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [REC_W-1:0] mk(input int ts, input logic [N_CH-1:0] m);
        return {TS_W'(ts), m};
    endfunction

    task automatic model_reset();
        mq.delete();
        m_prev = '1; m_sprev = 1'b0; m_pend = 1'b0; m_ovf = 1'b0; m_cnt = '0;
    endtask

    // one clock: predict, advance, compare at the falling edge
    task automatic step();
        logic [N_CH-1:0]  rise;
        logic             srise, wset, push, accept, drop, pop;
        logic [TS_W-1:0]  ts;
        logic [REC_W-1:0] rec, popped;
        srise  = (start_ext | start_host) & ~m_sprev;
        ts     = srise ? '0 : m_cnt;
        rise   = pulse_in & ~m_prev;
        wset   = !srise && (m_cnt == '1);
        push   = (rise != '0) || m_pend;
        rec    = {ts, rise};
        accept = push && (mq.size() < DEPTH);
        drop   = push && !accept;
        pop    = (mq.size() > 0) && rec_ready;
        @(posedge clk);
        if (pop) begin
            popped = mq.pop_front();
            if (popped[N_CH-1:0] == '0) markers++;
        end
        if (accept) mq.push_back(rec);
        if (m_pend && rise == '0) m_pend = 1'b0;
        else if (!m_pend && wset) m_pend = 1'b1;
        if (drop) m_ovf = 1'b1;
        else if (ovf_clear) m_ovf = 1'b0;
        m_cnt   = srise ? TS_W'(1) : m_cnt + TS_W'(1);
        m_prev  = pulse_in;
        m_sprev = start_ext | start_host;
        @(negedge clk);
        chk("R8 valid", 64'(rec_valid), 64'(mq.size() > 0));
        if (mq.size() > 0) chk("R2 R8 data", 64'(rec_data), 64'(mq[0]));
        chk("R9 R10 flag", 64'(ovf_flag), 64'(m_ovf));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        model_reset();
        pulse_in = 4'b0011;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 valid", 64'(rec_valid), 64'd0);
        chk("R11 flag", 64'(ovf_flag), 64'd0);
        rst_n = 1'b1;
        rec_ready = 1'b1;
        // R1: lines held high through reset give no tag
        step();
        chk("R1 held-through-reset", 64'(rec_valid), 64'd0);
        pulse_in = '0;
        step(); step();
        chk("R3 quiet", 64'(rec_valid), 64'd0);
        // R6: edge with start edge
        start_ext = 1'b1; pulse_in = 4'b0001;
        step();
        chk("R6 start-coincident", 64'(rec_data), 64'(mk(0, 4'b0001)));
        // R4 R5: held line and held start
        step();
        chk("R4 held no retag", 64'(rec_valid), 64'd0);
        start_ext = 1'b0; pulse_in = 4'b1010;
        step();
        chk("R2 R5 coincidence", 64'(rec_data), 64'(mk(2, 4'b1010)));
        pulse_in = 4'b0000;
        step();
        pulse_in = 4'b0010;
        step();
        chk("R4 retag after gap", 64'(rec_data), 64'(mk(4, 4'b0010)));
        // R5: host start
        pulse_in = '0; start_host = 1'b1;
        step();
        chk("R3 start alone", 64'(rec_valid), 64'd0);
        pulse_in = 4'b0100;
        step();
        chk("R5 host restart", 64'(rec_data), 64'(mk(1, 4'b0100)));
        start_host = 1'b0; pulse_in = '0;
        step();
        // R9: overflow with reader stalled
        rec_ready = 1'b0;
        for (int i = 0; i < 2 * DEPTH + 2; i++) begin
            pulse_in = (i % 2 == 0) ? 4'b0001 : 4'b0000;
            step();
        end
        chk("R9 flag set", 64'(ovf_flag), 64'd1);
        chk("R8 stalled valid", 64'(rec_valid), 64'd1);
        // R10: drop wins over clear
        ovf_clear = 1'b1; pulse_in = 4'b1000;
        step();
        chk("R10 drop beats clear", 64'(ovf_flag), 64'd1);
        pulse_in = '0;
        step();
        chk("R10 cleared", 64'(ovf_flag), 64'd0);
        ovf_clear = 1'b0;
        rec_ready = 1'b1;
        for (int i = 0; i < DEPTH + 2; i++) step();
        chk("R8 drained", 64'(rec_valid), 64'd0);
        // R7: wrap marker
        markers = 0;
        for (int i = 0; i < (1 << TS_W) + 8; i++) begin
            step();
            if (rec_valid && rec_data[N_CH-1:0] == '0)
                chk("R7 marker value", 64'(rec_data), 64'(mk(0, 4'b0000)));
        end
        chk("R7 one marker per wrap", 64'(markers), 64'd1);
        // random phase
        for (int i = 0; i < 5000; i++) begin
            for (int c = 0; c < N_CH; c++) pulse_in[c] = ($urandom % 3) == 0;
            start_ext  = ($urandom % 97) == 0;
            start_host = ($urandom % 131) == 0;
            ovf_clear  = ($urandom % 23) == 0;
            rec_ready  = ($urandom % 4) != 0;
            step();
        end
        finish_run();
    end
endmodule